// File: doc/BRIEF.md
# Edge-set read-clear interrupt source register

This block keeps one status bit per embedded sensor function in a single 8-bit source register. A bit becomes 1 on the rising edge of that function's interrupt request. A held high level does not set it again. Software reads the register to find which function raised an interrupt. Reading a function's own source register produces a clear strobe for that function, and the strobe drops the bit.

The data-ready bit is handled differently. It clears only once every axis high-byte data register (X, Y and Z) has been read since that bit was set. The reads may come in any order or in the same cycle. A read of the status register, on its own, leaves the data-ready bit untouched. Request inputs are registered once for edge detection. The register bits themselves drive the output.

Top module: `irq_source_reg`

## Requirements
- R1: After a synchronous reset every bit of `src_out` is 0.
- R2: A 0-to-1 change on a request line sets its bit in `src_out` at the first rising clock edge that samples the line high. A request held high after its bit was cleared does not set the bit again.
- R3: Each request line drives a fixed bit of `src_out`. `func_req[6:1]` drive bits 7 down to 2 in that order: auto-sleep, FIFO, transient, orientation, tap, freefall/motion. `func_req[0]` drives data-ready at bit 0.
- R4: A function bit (`src_out[7:2]`) clears at the clock edge that samples its own strobe `src_clr[i-1]` high, where i is the index of its request line.
- R5: A function bit is not changed by the strobes of other functions, by axis reads or by a status read.
- R6: Data-ready (bit 0) clears at the edge where all three axis reads (`axis_rd[0]`=X, `[1]`=Y, `[2]`=Z) have been seen since it was set. The reads may come in any order, including two or three together in one cycle.
- R7: A status read (`status_rd`) never clears data-ready and does not count as an axis read.
- R8: When a rising request edge and a clear condition for the same bit land on the same clock edge, the bit is 1 afterwards.
- R9: A new data-ready edge discards the axis reads seen so far. Axis reads made while data-ready is 0 are not counted.
- R10: Bit 1 of `src_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| func_req | input | 7 | Function interrupt requests; [0] data-ready, [6:1] functions for bits 7..2 |
| src_clr | input | 6 | Read-clear strobes; [i-1] clears the bit of func_req[i] |
| axis_rd | input | 3 | High-byte data register read strobes: [0] X, [1] Y, [2] Z |
| status_rd | input | 1 | Status register read strobe |
| src_out | output | 8 | Interrupt source register |

## Verification
The assertions assume that every strobe lasts one clock cycle per register read and is synchronous to `clk`. They also assume that request lines change only between clock edges. Because of that, a `$rose` seen on a request port matches the edge that the internal delay stage detects. The bench changes every input on the falling edge and holds each strobe for exactly one cycle. Each request is returned low before it is raised again, so every edge it produces is deliberate.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int NUM_FUNC = 6;
  localparam int NUM_AXIS = 3;
  localparam int REG_W    = NUM_FUNC + 2;
  localparam int DRDY_BIT = 0;
  localparam int RSVD_BIT = 1;
  localparam int FUNC_LSB = 2;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  AST_CELL_HOLD:   assert property (@(posedge clk) disable iff (rst) q && !clr_i |=> q);      // R5
  AST_CELL_NOSET:  assert property (@(posedge clk) disable iff (rst) !q && !set_i |=> !q);    // R2
  AST_CELL_SETWIN: assert property (@(posedge clk) disable iff (rst) set_i && clr_i |=> q);   // R8
endmodule

// File: rtl/irq_drdy_track.sv
module irq_drdy_track #(
  parameter int NAXIS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [NAXIS-1:0] axis_rd,
  output logic             q
);
  logic [NAXIS-1:0] seen_q;
  logic [NAXIS-1:0] seen_nx;
  logic             all_read;

  assign seen_nx  = seen_q | axis_rd;
  assign all_read = &seen_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      seen_q <= '0;
    end else if (set_i) begin
      q      <= 1'b1;
      seen_q <= '0;
    end else if (q && all_read) begin
      q      <= 1'b0;
      seen_q <= '0;
    end else if (q) begin
      seen_q <= seen_nx;
    end
  end

  AST_DRDY_NOSET:   assert property (@(posedge clk) disable iff (rst) !q && !set_i |=> !q);                 // R9
  AST_DRDY_PARTIAL: assert property (@(posedge clk) disable iff (rst) q && !set_i && !all_read |=> q);      // R6
  AST_DRDY_CLEAR:   assert property (@(posedge clk) disable iff (rst) q && !set_i && all_read |=> !q);      // R6
  AST_DRDY_SETWIN:  assert property (@(posedge clk) disable iff (rst) set_i |=> q && seen_q == '0);         // R8
endmodule

// File: rtl/irq_source_reg.sv
module irq_source_reg
  import irq_src_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC:0]   func_req,
  input  logic [NUM_FUNC-1:0] src_clr,
  input  logic [NUM_AXIS-1:0] axis_rd,
  input  logic                status_rd,
  output logic [REG_W-1:0]    src_out
);
  logic [NUM_FUNC:0]   rise;
  logic [NUM_FUNC-1:0] func_q;
  logic                drdy_q;

  irq_edge_detect #(.W(NUM_FUNC + 1)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (func_req),
    .rise   (rise)
  );

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_func
    irq_src_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (rise[i+1]),
      .clr_i (src_clr[i]),
      .q     (func_q[i])
    );
  end

  irq_drdy_track #(.NAXIS(NUM_AXIS)) u_drdy (
    .clk     (clk),
    .rst     (rst),
    .set_i   (rise[0]),
    .axis_rd (axis_rd),
    .q       (drdy_q)
  );

  always_comb begin
    src_out           = '0;
    src_out[DRDY_BIT] = drdy_q;
    src_out[RSVD_BIT] = 1'b0;
    src_out[REG_W-1:FUNC_LSB] = func_q;
  end

  AST_STATUS_NOCLR: assert property (@(posedge clk) disable iff (rst)
    src_out[DRDY_BIT] && status_rd && axis_rd == '0 |=> src_out[DRDY_BIT]);                          // R7
  AST_DRDY_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    $rose(func_req[0]) |=> src_out[DRDY_BIT]);                                                       // R2
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (rst) !src_out[RSVD_BIT]);                // R10
  for (genvar k = 1; k <= NUM_FUNC; k++) begin : g_chk
    AST_FUNC_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
      $rose(func_req[k]) |=> src_out[k+1]);                                                          // R3
    AST_FUNC_OWN_CLR: assert property (@(posedge clk) disable iff (rst)
      src_clr[k-1] && !$rose(func_req[k]) |=> !src_out[k+1]);                                        // R4
  end
endmodule

// File: tb/sim_irq_source_reg.sv
module sim_irq_source_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] func_req;
  logic [5:0] src_clr;
  logic [2:0] axis_rd;
  logic       status_rd;
  logic [7:0] src_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_source_reg u0 (
    .clk(clk), .rst(rst), .func_req(func_req), .src_clr(src_clr),
    .axis_rd(axis_rd), .status_rd(status_rd), .src_out(src_out)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] exp);
    checks++;
    if (src_out !== exp) begin
      errors++;
      $display("FAIL %s: src_out=%02h expected=%02h", req, src_out, exp);
    end
  endtask

  task automatic drdy_set();
    func_req[0] = 1'b1; cyc();
    func_req[0] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; func_req = '0; src_clr = '0; axis_rd = '0; status_rd = 1'b0;
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    chk("R1", 8'h00);

    // Function bits: request line k maps to bit k+1 (R3)
    for (int k = 1; k <= 6; k++) begin
      logic [7:0] b;
      b = 8'h01 << (k + 1);
      func_req[k] = 1'b1; cyc();
      chk("R2/R3 set on edge", b);
      src_clr[k-1] = 1'b1; cyc(); src_clr = '0;
      chk("R4 own clear", 8'h00);
      cyc();
      chk("R2 held level no reset", 8'h00);
      func_req[k] = 1'b0; cyc();
      func_req[k] = 1'b1; cyc();
      chk("R2 second edge", b);
      src_clr = ~(6'b1 << (k - 1)); axis_rd = 3'b111; status_rd = 1'b1; cyc();
      src_clr = '0; axis_rd = '0; status_rd = 1'b0;
      chk("R5 foreign strobes", b);
      func_req[k] = 1'b0; cyc();
      func_req[k] = 1'b1; src_clr[k-1] = 1'b1; cyc(); src_clr = '0;
      chk("R8 edge beats clear", b);
      func_req[k] = 1'b0; src_clr[k-1] = 1'b1; cyc(); src_clr = '0;
      chk("R4 clear after coincidence", 8'h00);
    end

    // Data-ready: all six read orders, status read mixed in
    for (int a = 0; a < 3; a++)
      for (int bb = 0; bb < 3; bb++)
        for (int c = 0; c < 3; c++) begin
          if (a == bb || a == c || bb == c) continue;
          drdy_set();
          chk("R2/R3 drdy set", 8'h01);
          status_rd = 1'b1; cyc(); status_rd = 1'b0;
          chk("R7 status read", 8'h01);
          axis_rd = 3'b1 << a; cyc(); axis_rd = '0;
          chk("R6 one read", 8'h01);
          axis_rd = 3'b1 << bb; status_rd = 1'b1; cyc(); axis_rd = '0; status_rd = 1'b0;
          chk("R6/R7 two reads", 8'h01);
          axis_rd = 3'b1 << c; cyc(); axis_rd = '0;
          chk("R6 all reads clear", 8'h00);
        end

    // Same-cycle reads of all axes, and every pair then remainder
    drdy_set(); axis_rd = 3'b111; cyc(); axis_rd = '0;
    chk("R6 simultaneous", 8'h00);
    for (int p = 0; p < 3; p++) begin
      drdy_set();
      axis_rd = ~(3'b1 << p); cyc(); axis_rd = '0;
      chk("R6 pair read", 8'h01);
      axis_rd = 3'b1 << p; cyc(); axis_rd = '0;
      chk("R6 pair then last", 8'h00);
    end

    // Reads while clear are not counted (R9)
    axis_rd = 3'b011; cyc(); axis_rd = '0;
    drdy_set();
    axis_rd = 3'b100; cyc(); axis_rd = '0;
    chk("R9 prior reads ignored", 8'h01);
    axis_rd = 3'b011; cyc(); axis_rd = '0;
    chk("R9 fresh reads clear", 8'h00);

    // New edge mid-sequence restarts tracking (R9)
    drdy_set();
    axis_rd = 3'b011; cyc(); axis_rd = '0;
    drdy_set();
    axis_rd = 3'b100; cyc(); axis_rd = '0;
    chk("R9 restart", 8'h01);
    axis_rd = 3'b011; cyc(); axis_rd = '0;
    chk("R9 restart complete", 8'h00);

    // Edge coinciding with final read keeps bit (R8)
    drdy_set();
    axis_rd = 3'b011; cyc();
    func_req[0] = 1'b1; axis_rd = 3'b100; cyc(); func_req[0] = 1'b0; axis_rd = '0;
    chk("R8 drdy edge beats clear", 8'h01);
    axis_rd = 3'b111; cyc(); axis_rd = '0;
    chk("R6 final clear", 8'h00);

    // Everything asserted: reserved bit stays low (R10)
    func_req = 7'h7F; cyc();
    chk("R10 reserved low", 8'hFD);
    cyc(); func_req = '0;

    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1 reset clears", 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule